// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the timing skeleton for a parallel RGB display panel. It outputs horizontal and vertical sync, a data-enable strobe, a divided pixel clock, a single-cycle pixel step enable and a panel power enable. Downstream pixel-fetch and colour logic receives the running pixel and line positions and a phase code for each axis. Pixel data itself is not handled here.

Software programs four packed words: one horizontal timing word, two vertical timing words and a polarity/divider word. Most fields are stored minus one. The horizontal active width is counted in units of 16 pixels. The two vertical porches are stored as plain counts and may be zero. The timing runs only while both the controller-enable and screen-on inputs are high. Any word written during a frame is held back and applied at the next frame boundary, so the frame in progress keeps a single geometry.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `ctrl_en_i` or `screen_on_i` is low, the block is idle. Both position counters are zero. `pix_en_o` is low. `hsync_o`, `vsync_o`, `de_o` and `pclk_o` show their inactive level, which is 0 XOR the matching polarity bit.
- R2: With divider field D = `pol_i[14:8]` + 1 (range 1..128), `pix_en_o` is high for exactly one input clock in every D once running, starting D-1 clocks after the block leaves idle.
- R3: Within each D-clock pixel period, the raw pixel clock is low for the first floor(D/2) input clocks and high for the rest. `pclk_o` is this raw value XOR `pol_i[2]`. For D=1 the raw pixel clock stays high.
- R4: The line length in pixel steps equals hsync + hbp + act + hfp. Here hsync = `htim_i[15:8]`+1, hfp = `htim_i[23:16]`+1, hbp = `htim_i[31:24]`+1 and act = (`htim_i[7:0]`+1)·16. `h_cnt_o` counts 0 to length-1 and advances only on `pix_en_o`.
- R5: Each line runs in this order: sync, back porch, active, front porch. `hsync_o` XOR `pol_i[1]` is high exactly during the sync part.
- R6: The frame length in lines equals vsync + vbp + lines + vfp. Here lines = `vtim0_i[11:0]`+1, vsync = `vtim0_i[21:16]`+1, vfp = `vtim0_i[31:24]` unbiased, and vbp = `vtim1_i[7:0]` unbiased. A zero porch is skipped. `v_cnt_o` steps when a line wraps.
- R7: The frame uses the same sync, back porch, active, front porch order in lines. `vsync_o` XOR `pol_i[0]` is high exactly during the vertical sync lines.
- R8: `de_o` XOR `pol_i[3]` is high only when both axes are in their active phase.
- R9: `pwr_en_o` equals (running) XOR `pol_i[4]`.
- R10: Timing and polarity words are captured while idle and at the last pixel step of a frame. A change made mid-frame leaves the current frame unchanged.
- R11: `h_phase_o` and `v_phase_o` encode the current part of the axis as 0 = sync, 1 = back porch, 2 = active, 3 = front porch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_en_i | input | 1 | Controller enable |
| screen_on_i | input | 1 | Screen on |
| htim_i | input | 32 | Packed horizontal timing word |
| vtim0_i | input | 32 | Packed vertical word: lines, sync, front porch |
| vtim1_i | input | 32 | Packed vertical word: back porch |
| pol_i | input | 15 | Polarity bits [4:0], divider minus one [14:8] |
| pix_en_o | output | 1 | One-clock pixel step enable |
| pclk_o | output | 1 | Divided pixel clock to panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pwr_en_o | output | 1 | Panel power enable |
| h_cnt_o | output | 13 | Pixel position within the line |
| v_cnt_o | output | 13 | Line position within the frame |
| h_phase_o | output | 2 | Horizontal phase code |
| v_phase_o | output | 2 | Vertical phase code |

## Verification
A bench model predicts every output on every clock and is driven with several kinds of patterns.

Random small geometries with random polarity and dividers 1 to 3 separate errors in field decoding and bias handling from errors in phase ordering. An odd divider in particular exposes a wrong pclk duty split.

A directed geometry with both vertical porches at zero checks that empty phases are skipped rather than counted once. Setting only one of the two enable inputs, with every polarity bit inverted, shows whether the idle levels honour polarity.

A rewrite of all four words in the middle of a frame tells apart an immediate update from one deferred to the frame boundary.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  localparam int DEF_CNT_W = 13;
  localparam int DEF_DIV_W = 7;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;
endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             en_o,
  output logic             pclk_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   half;

  assign half   = ({1'b0, div_m1_i} + {{DIV_W{1'b0}}, 1'b1}) >> 1;
  assign en_o   = run_i && (cnt_q == div_m1_i);
  assign pclk_o = run_i && ({1'b0, cnt_q} >= half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || en_o)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_axis_cnt.sv
module lcd_axis_cnt
  import lcd_timing_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] len_sync_i,
  input  logic [CNT_W-1:0] len_back_i,
  input  logic [CNT_W-1:0] len_act_i,
  input  logic [CNT_W-1:0] len_front_i,
  output logic [CNT_W-1:0] cnt_o,
  output phase_e           phase_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, end_sync, end_back, end_act, total;

  // phase boundaries; zero-length parts fall out of the compare chain
  assign end_sync = len_sync_i;
  assign end_back = end_sync + len_back_i;
  assign end_act  = end_back + len_act_i;
  assign total    = end_act + len_front_i;
  assign last_o   = (cnt_q == total - 1'b1);

  always_comb begin
    if (cnt_q < end_sync)      phase_o = PH_SYNC;
    else if (cnt_q < end_back) phase_o = PH_BACK;
    else if (cnt_q < end_act)  phase_o = PH_ACT;
    else                       phase_o = PH_FRONT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int DIV_W = DEF_DIV_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_en_i,
  input  logic               screen_on_i,
  input  logic [31:0]        htim_i,
  input  logic [31:0]        vtim0_i,
  input  logic [31:0]        vtim1_i,
  input  logic [DIV_W+7:0]   pol_i,
  output logic               pix_en_o,
  output logic               pclk_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               pwr_en_o,
  output logic [CNT_W-1:0]   h_cnt_o,
  output logic [CNT_W-1:0]   v_cnt_o,
  output logic [1:0]         h_phase_o,
  output logic [1:0]         v_phase_o
);
  localparam int POL_W = DIV_W + 8;
  localparam int ACT_SHIFT = 4;

  logic             run, pix_en, pclk_raw, h_last, v_last, frame_end;
  logic [31:0]      htim_q, vtim0_q, vtim1_q;
  logic [POL_W-1:0] pol_q;
  logic [CNT_W-1:0] hs_len, hb_len, ha_len, hf_len;
  logic [CNT_W-1:0] vs_len, vb_len, va_len, vf_len;
  phase_e           h_ph, v_ph;

  assign run       = ctrl_en_i & screen_on_i;
  assign frame_end = pix_en & h_last & v_last;

  // shadow copy: tracks inputs while idle, otherwise reloads only at frame end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      htim_q  <= '0;
      vtim0_q <= '0;
      vtim1_q <= '0;
      pol_q   <= '0;
    end else if (!run || frame_end) begin
      htim_q  <= htim_i;
      vtim0_q <= vtim0_i;
      vtim1_q <= vtim1_i;
      pol_q   <= pol_i;
    end
  end

  assign hs_len = CNT_W'(htim_q[15:8])  + 1'b1;
  assign hf_len = CNT_W'(htim_q[23:16]) + 1'b1;
  assign hb_len = CNT_W'(htim_q[31:24]) + 1'b1;
  assign ha_len = (CNT_W'(htim_q[7:0]) + 1'b1) << ACT_SHIFT;
  assign va_len = CNT_W'(vtim0_q[11:0])  + 1'b1;
  assign vs_len = CNT_W'(vtim0_q[21:16]) + 1'b1;
  assign vf_len = CNT_W'(vtim0_q[31:24]);
  assign vb_len = CNT_W'(vtim1_q[7:0]);

  lcd_pclk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .div_m1_i (pol_q[DIV_W+7:8]),
    .en_o     (pix_en),
    .pclk_o   (pclk_raw)
  );

  lcd_axis_cnt #(.CNT_W(CNT_W)) i_h_axis (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .step_i      (pix_en),
    .len_sync_i  (hs_len),
    .len_back_i  (hb_len),
    .len_act_i   (ha_len),
    .len_front_i (hf_len),
    .cnt_o       (h_cnt_o),
    .phase_o     (h_ph),
    .last_o      (h_last)
  );

  lcd_axis_cnt #(.CNT_W(CNT_W)) i_v_axis (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .step_i      (pix_en & h_last),
    .len_sync_i  (vs_len),
    .len_back_i  (vb_len),
    .len_act_i   (va_len),
    .len_front_i (vf_len),
    .cnt_o       (v_cnt_o),
    .phase_o     (v_ph),
    .last_o      (v_last)
  );

  assign pix_en_o  = pix_en;
  assign pclk_o    = pclk_raw ^ pol_q[2];
  assign hsync_o   = (run && h_ph == PH_SYNC) ^ pol_q[1];
  assign vsync_o   = (run && v_ph == PH_SYNC) ^ pol_q[0];
  assign de_o      = (run && h_ph == PH_ACT && v_ph == PH_ACT) ^ pol_q[3];
  assign pwr_en_o  = run ^ pol_q[4];
  assign h_phase_o = h_ph;
  assign v_phase_o = v_ph;
endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk #(
  parameter int CNT_W = 13,
  parameter int POL_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [POL_W-1:0] pol_s_i,
  input logic             pix_en_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             de_o,
  input logic [CNT_W-1:0] h_cnt_o,
  input logic [CNT_W-1:0] v_cnt_o,
  input logic [1:0]       h_phase_o,
  input logic [1:0]       v_phase_o
);
  // R1
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (h_cnt_o == '0) && (v_cnt_o == '0));
  // R2
  step_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |-> run_i);
  // R4
  h_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !pix_en_o) |=> $stable(h_cnt_o));
  // R5
  hsync_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_o != pol_s_i[1]) |-> (h_phase_o == 2'd0));
  // R7
  vsync_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_o != pol_s_i[0]) |-> (v_phase_o == 2'd0));
  // R8
  de_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o != pol_s_i[3]) |-> (h_phase_o == 2'd2) && (v_phase_o == 2'd2));
endmodule

bind lcd_timing_gen lcd_timing_chk #(.CNT_W(CNT_W), .POL_W(POL_W)) i_lcd_timing_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run),
  .pol_s_i   (pol_q),
  .pix_en_o  (pix_en_o),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .de_o      (de_o),
  .h_cnt_o   (h_cnt_o),
  .v_cnt_o   (v_cnt_o),
  .h_phase_o (h_phase_o),
  .v_phase_o (v_phase_o)
);

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  localparam int CLK_P = 10;
  localparam int WDOG  = 190000;

  logic        clk_i = 1'b0, rst_ni = 1'b0, ctrl_en_i = 1'b0, screen_on_i = 1'b0;
  logic [31:0] htim_i = '0, vtim0_i = '0, vtim1_i = '0;
  logic [14:0] pol_i = '0;
  logic        pix_en_o, pclk_o, hsync_o, vsync_o, de_o, pwr_en_o;
  logic [12:0] h_cnt_o, v_cnt_o;
  logic [1:0]  h_phase_o, v_phase_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit checking = 1'b0, mid_change = 1'b0;

  lcd_timing_gen i_lcd_timing_gen (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  // reference state
  logic [31:0] m_h, m_v0, m_v1;
  logic [14:0] m_pol;
  int m_d, m_x, m_y;

  function automatic int h_tot(logic [31:0] r);
    return (r[15:8] + 1) + (r[31:24] + 1) + (r[23:16] + 1) + (r[7:0] + 1) * 16;
  endfunction
  function automatic int v_tot(logic [31:0] r0, logic [31:0] r1);
    return (r0[11:0] + 1) + (r0[21:16] + 1) + r0[31:24] + r1[7:0];
  endfunction
  function automatic int phase(int p, int s, int b, int a);
    if (p < s) return 0;
    if (p < s + b) return 1;
    if (p < s + b + a) return 2;
    return 3;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin : mdl
    bit run, pix, fend;
    int dv;
    if (!rst_ni) begin
      m_h <= '0; m_v0 <= '0; m_v1 <= '0; m_pol <= '0;
      m_d <= 0; m_x <= 0; m_y <= 0;
    end else begin
      run  = ctrl_en_i && screen_on_i;
      dv   = int'(m_pol[14:8]) + 1;
      pix  = run && (m_d == dv - 1);
      fend = pix && (m_x == h_tot(m_h) - 1) && (m_y == v_tot(m_v0, m_v1) - 1);
      if (!run) begin
        m_d <= 0; m_x <= 0; m_y <= 0;
      end else begin
        m_d <= pix ? 0 : m_d + 1;
        if (pix) begin
          if (m_x == h_tot(m_h) - 1) begin
            m_x <= 0;
            m_y <= (m_y == v_tot(m_v0, m_v1) - 1) ? 0 : m_y + 1;
          end else m_x <= m_x + 1;
        end
      end
      if (!run || fend) begin
        m_h <= htim_i; m_v0 <= vtim0_i; m_v1 <= vtim1_i; m_pol <= pol_i;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin : cmp
    bit run;
    int dv, hp, vp;
    if (checking && rst_ni) begin
      run = ctrl_en_i && screen_on_i;
      dv  = int'(m_pol[14:8]) + 1;
      hp  = phase(m_x, m_h[15:8] + 1, m_h[31:24] + 1, (m_h[7:0] + 1) * 16);
      vp  = phase(m_y, m_v0[21:16] + 1, m_v1[7:0], m_v0[11:0] + 1);
      chk(run ? "R2 pix_en" : "R1 pix_en", pix_en_o, run && (m_d == dv - 1));
      chk(run ? "R3 pclk" : "R1 pclk", pclk_o, (run && (m_d >= dv / 2)) ^ m_pol[2]);
      chk(run ? "R5 hsync" : "R1 hsync", hsync_o, (run && hp == 0) ^ m_pol[1]);
      chk(run ? "R7 vsync" : "R1 vsync", vsync_o, (run && vp == 0) ^ m_pol[0]);
      chk(run ? "R8 de" : "R1 de", de_o, (run && hp == 2 && vp == 2) ^ m_pol[3]);
      chk("R9 pwr", pwr_en_o, run ^ m_pol[4]);
      chk(mid_change ? "R10 h_cnt" : (run ? "R4 h_cnt" : "R1 h_cnt"), h_cnt_o, m_x);
      chk(mid_change ? "R10 v_cnt" : (run ? "R6 v_cnt" : "R1 v_cnt"), v_cnt_o, m_y);
      if (run) begin
        chk("R11 h_phase", h_phase_o, hp);
        chk("R11 v_phase", v_phase_o, vp);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      n_err++;
      $display("FAIL R1 watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic cfg(logic [31:0] h, logic [31:0] v0, logic [31:0] v1, logic [14:0] p);
    ctrl_en_i = 1'b0;
    tick(2);
    htim_i = h; vtim0_i = v0; vtim1_i = v1; pol_i = p;
    tick(2);
  endtask

  function automatic int frame_cyc(logic [31:0] h, logic [31:0] v0, logic [31:0] v1,
                                   logic [14:0] p);
    return h_tot(h) * v_tot(v0, v1) * (int'(p[14:8]) + 1);
  endfunction

  task automatic run_frames(int f);
    ctrl_en_i = 1'b1; screen_on_i = 1'b1;
    tick(f * frame_cyc(htim_i, vtim0_i, vtim1_i, pol_i) + 7);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    checking = 1'b1;
    tick(3);
    // R1 reset state
    chk("R1 reset h_cnt", h_cnt_o, 0);
    chk("R1 reset hsync", hsync_o, 0);
    rst_ni = 1'b1;
    tick(2);

    // R4 R5 R6 R7: plain geometry, divider 1
    cfg({8'd2, 8'd1, 8'd0, 8'd0}, {8'd1, 2'b0, 6'd1, 4'b0, 12'd3}, 32'd2, 15'h0000);
    run_frames(2);

    // R1: only one enable, all polarities inverted, divider 3
    cfg({8'd0, 8'd0, 8'd1, 8'd1}, {8'd0, 2'b0, 6'd0, 4'b0, 12'd2}, 32'd1, {7'd2, 3'b0, 5'h1f});
    screen_on_i = 1'b0; ctrl_en_i = 1'b1;
    tick(40);
    chk("R1 idle de", de_o, 1);
    chk("R1 idle pclk", pclk_o, 1);
    screen_on_i = 1'b1; ctrl_en_i = 1'b0;
    tick(20);
    run_frames(1);

    // R6: both vertical porches zero, even divider
    cfg({8'd0, 8'd0, 8'd0, 8'd0}, {8'd0, 2'b0, 6'd2, 4'b0, 12'd1}, 32'd0, {7'd1, 3'b0, 5'h05});
    run_frames(2);

    // R10: rewrite every word mid-frame
    cfg({8'd1, 8'd1, 8'd1, 8'd0}, {8'd1, 2'b0, 6'd0, 4'b0, 12'd2}, 32'd1, 15'h0000);
    ctrl_en_i = 1'b1; screen_on_i = 1'b1;
    tick(frame_cyc(htim_i, vtim0_i, vtim1_i, pol_i) / 2);
    mid_change = 1'b1;
    htim_i = {8'd3, 8'd2, 8'd3, 8'd1}; vtim0_i = {8'd2, 2'b0, 6'd2, 4'b0, 12'd4};
    vtim1_i = 32'd2; pol_i = {7'd2, 3'b0, 5'h0a};
    tick(frame_cyc(32'h01010100, 32'h01000002, 32'd1, 15'h0) / 2 + 2);
    mid_change = 1'b0;
    tick(2 * frame_cyc(htim_i, vtim0_i, vtim1_i, pol_i) + 5);

    // random geometries: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int k = 0; k < 15; k++) begin
      cfg({8'($urandom % 4), 8'($urandom % 4), 8'($urandom % 4), 8'($urandom % 2)},
          {8'($urandom % 3), 2'b0, 6'($urandom % 3), 4'b0, 12'($urandom % 6)},
          {24'b0, 8'($urandom % 3)},
          {7'($urandom % 3), 3'b0, 5'($urandom % 32)});
      run_frames(2);
    end

    checking = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule